// File: doc/BRIEF.md
# External Bus Wait-State Sequencer

This block runs one access at a time from a single chip select to an asynchronous external memory or peripheral. A request (direction, address, write data) is accepted through a valid/ready handshake. The sequencer then walks through three timed phases: setup, strobe pulse and hold. Reads and writes each have their own programmable lengths. The block drives the address bus, the write data bus with its output enable, and the active-low read and write strobes. When the access ends, a single-cycle completion pulse is raised, carrying the captured read data.

An active-low wait pin lets the external device stretch an access. The pin is brought into the clock domain through a two-flop synchronizer, so the sequencer sees it two cycles late. It is looked at only while a strobe is in its pulse phase. A two-bit mode field selects how the pin is treated. In frozen mode, the pin stops the access in place. In ready mode, the pulse stalls at its last cycle until the device releases the pin. Any other mode ignores the pin.

After a read, a programmable number of data-float cycles must pass before the external bus may be driven again. These cycles are counted from the first hold cycle of the read. A write that arrives during the remaining float time is held off. A read arriving at that time is accepted at once.

Top module: `xbusSeq`

## Requirements
- R1: While reset is active, and in the first cycle after it, both strobes are high (inactive), the data output enable is 0, the completion pulse is 0 and the request ready is 1.
- R2: An accepted access spends S setup cycles, then max(P,1) pulse cycles with its strobe low, then H hold cycles. S, P and H are taken from the read fields for a read and from the write fields for a write. Counting the cycle after acceptance as cycle 1, the strobe first falls in cycle S+1 and the completion pulse is high for exactly the single cycle S+max(P,1)+H+1.
- R3: The data output enable is 1 only during the setup, pulse and hold cycles of a write, and is never 1 while the read strobe is low. The address bus holds the request address throughout the access. During a write, the data bus carries the request write data.
- R4: Read data is the value on the input data bus in the last pulse cycle of a read. It is shown on the read data output while the completion pulse is high, and it stays unchanged until the next capture.
- R5: The wait mode field is decoded as follows: 0 or 1 ignore the wait pin, 2 selects frozen mode and 3 selects ready mode. The wait pin is active low and reaches the sequencer through a two-flop synchronizer, which adds two cycles of latency.
- R6: In frozen mode, each pulse cycle that sees the synchronized wait asserted is frozen. The strobes, address, data bus and output enable do not change in such a cycle, and the access later resumes where it stopped. A wait pin held low for W cycles during the pulse therefore lengthens the pulse and the access by exactly W cycles.
- R7: In ready mode, the pulse counts down normally and then repeats its last cycle for as long as the synchronized wait is asserted. Hold begins only after the synchronized wait is seen deasserted.
- R8: A wait pin asserted so that its synchronized value falls only in setup, hold or idle cycles has no effect on access timing.
- R9: The configuration-invalid output is 1 exactly when the wait mode is 2 or 3 and either the read hold or the write hold count is zero.
- R10: After a read with hold H and float count F, a write is accepted no earlier than the last of max(F-H,0) float cycles that follow the read's hold. If the write is waiting at completion, it is stalled for max(F-H-1,0) extra cycles.
- R11: Request ready is 0 during setup, pulse and hold. It is 1 in idle. During float it is 1 for a read request, and for a write request only in the last float cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Request address |
| reqWdata | input | DATA_W | Request write data |
| reqReady | output | 1 | Request accepted on a clock edge where valid and ready are both 1 |
| cfgRdSetup | input | CNT_W | Read setup cycles |
| cfgRdPulse | input | CNT_W | Read pulse cycles (0 treated as 1) |
| cfgRdHold | input | CNT_W | Read hold cycles |
| cfgWrSetup | input | CNT_W | Write setup cycles |
| cfgWrPulse | input | CNT_W | Write pulse cycles (0 treated as 1) |
| cfgWrHold | input | CNT_W | Write hold cycles |
| cfgFloat | input | CNT_W | Data-float cycles after a read, counted from its first hold cycle |
| cfgWaitMode | input | 2 | Wait mode: 0/1 off, 2 frozen, 3 ready |
| waitN | input | 1 | Asynchronous active-low wait from the device |
| busAddr | output | ADDR_W | External address bus |
| busDataOut | output | DATA_W | External data bus, output value |
| busDataOe | output | 1 | External data bus output enable |
| busDataIn | input | DATA_W | External data bus, input value |
| rdStrobeN | output | 1 | Active-low read strobe |
| wrStrobeN | output | 1 | Active-low write strobe |
| doneValid | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Captured read data |
| cfgInvalid | output | 1 | Wait enabled with a zero hold count |

## Verification
The delicate overlap is between a synchronized wait assertion and the pulse counter's own countdown or terminal cycle. In frozen mode, the wait pin is pulled low in the first pulse cycle and released W cycles later, so that the freeze lands in the middle of the countdown. The pulse width, the completion cycle and the captured read data are then compared with values computed from S+P+W+H. In ready mode, the release cycle is swept before, at and after the terminal count, and the stall length is judged as max(S+P, release+2)-S. A second overlap, completion in the same cycle as a waiting write entering float, is covered by sweeping the float count against the read hold and counting stall cycles.

// File: rtl/xbusPkg.sv
`timescale 1ns/1ps
package xbusPkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_SETUP = 3'd1,
    PH_PULSE = 3'd2,
    PH_HOLD  = 3'd3,
    PH_FLOAT = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    WM_OFF    = 2'd0,
    WM_RSVD   = 2'd1,
    WM_FROZEN = 2'd2,
    WM_READY  = 2'd3
  } waitMode_e;

  // Strobes from control to datapath
  typedef struct packed {
    phase_e phase;
    logic   isWrite;
    logic   load;
    logic   capture;
  } seqStrobe_t;

endpackage

// File: rtl/xbusWaitSync.sv
`timescale 1ns/1ps
module xbusWaitSync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic waitN,
  output logic waitAct
);
  localparam int LAST = STAGES - 1;

  logic [LAST:0] chain;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '1;
        else       chain <= waitN;
      end
    end else begin : g_multi
      always_ff @(posedge clk) begin
        if (!rstN) chain <= '1;
        else       chain <= {chain[LAST-1:0], waitN};
      end
    end
  endgenerate

  assign waitAct = ~chain[LAST];
endmodule

// File: rtl/xbusSeqCtrl.sv
`timescale 1ns/1ps
module xbusSeqCtrl
  import xbusPkg::*;
#(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             reqValid,
  input  logic             reqWrite,
  output logic             reqReady,
  input  logic [CNT_W-1:0] cfgRdSetup,
  input  logic [CNT_W-1:0] cfgRdPulse,
  input  logic [CNT_W-1:0] cfgRdHold,
  input  logic [CNT_W-1:0] cfgWrSetup,
  input  logic [CNT_W-1:0] cfgWrPulse,
  input  logic [CNT_W-1:0] cfgWrHold,
  input  logic [CNT_W-1:0] cfgFloat,
  input  logic [1:0]       cfgWaitMode,
  input  logic             waitAct,
  output logic             doneValid,
  output logic             cfgInvalid,
  output seqStrobe_t       strb
);
  localparam logic [CNT_W-1:0] CNT_ZERO = '0;
  localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

  phase_e           phase, phaseNxt;
  logic [CNT_W-1:0] cnt, cntNxt;
  logic             isWr, isWrNxt;
  logic             doneNxt;
  logic             loadNow, captureNow, finishNow;

  logic [CNT_W-1:0] curPulse, curHold, reqSetup, reqPulse;
  logic [CNT_W-1:0] floatExtra;
  logic             frozenMode, readyMode, accept;

  assign frozenMode = (cfgWaitMode == WM_FROZEN);
  assign readyMode  = (cfgWaitMode == WM_READY);
  assign cfgInvalid = cfgWaitMode[1] && ((cfgRdHold == CNT_ZERO) || (cfgWrHold == CNT_ZERO));

  assign curPulse = isWr ? cfgWrPulse : cfgRdPulse;
  assign curHold  = isWr ? cfgWrHold  : cfgRdHold;
  assign reqSetup = reqWrite ? cfgWrSetup : cfgRdSetup;
  assign reqPulse = reqWrite ? cfgWrPulse : cfgRdPulse;

  // float cycles still owed after the read's hold has run
  assign floatExtra = (cfgFloat > cfgRdHold) ? (cfgFloat - cfgRdHold) : CNT_ZERO;

  function automatic logic [CNT_W-1:0] pulseLoad(input logic [CNT_W-1:0] p);
    return (p == CNT_ZERO) ? CNT_ZERO : (p - CNT_ONE);
  endfunction

  always_comb begin
    reqReady = 1'b0;
    case (phase)
      PH_IDLE:  reqReady = 1'b1;
      PH_FLOAT: reqReady = !reqWrite || (cnt == CNT_ZERO);
      default:  reqReady = 1'b0;
    endcase
  end

  assign accept = reqValid && reqReady;

  always_comb begin
    phaseNxt   = phase;
    cntNxt     = cnt;
    isWrNxt    = isWr;
    doneNxt    = 1'b0;
    loadNow    = 1'b0;
    captureNow = 1'b0;
    finishNow  = 1'b0;
    case (phase)
      PH_IDLE, PH_FLOAT: begin
        if (accept) begin
          loadNow = 1'b1;
          isWrNxt = reqWrite;
          if (reqSetup != CNT_ZERO) begin
            phaseNxt = PH_SETUP;
            cntNxt   = reqSetup - CNT_ONE;
          end else begin
            phaseNxt = PH_PULSE;
            cntNxt   = pulseLoad(reqPulse);
          end
        end else if (phase == PH_FLOAT) begin
          if (cnt == CNT_ZERO) phaseNxt = PH_IDLE;
          else                 cntNxt   = cnt - CNT_ONE;
        end
      end
      PH_SETUP: begin
        if (cnt == CNT_ZERO) begin
          phaseNxt = PH_PULSE;
          cntNxt   = pulseLoad(curPulse);
        end else begin
          cntNxt = cnt - CNT_ONE;
        end
      end
      PH_PULSE: begin
        if (frozenMode && waitAct) begin
          phaseNxt = phase;
        end else if (cnt != CNT_ZERO) begin
          cntNxt = cnt - CNT_ONE;
        end else if (readyMode && waitAct) begin
          phaseNxt = phase;
        end else begin
          captureNow = !isWr;
          if (curHold != CNT_ZERO) begin
            phaseNxt = PH_HOLD;
            cntNxt   = curHold - CNT_ONE;
          end else begin
            finishNow = 1'b1;
          end
        end
      end
      PH_HOLD: begin
        if (cnt == CNT_ZERO) finishNow = 1'b1;
        else                 cntNxt    = cnt - CNT_ONE;
      end
      default: phaseNxt = PH_IDLE;
    endcase

    if (finishNow) begin
      doneNxt = 1'b1;
      if (!isWr && (floatExtra != CNT_ZERO)) begin
        phaseNxt = PH_FLOAT;
        cntNxt   = floatExtra - CNT_ONE;
      end else begin
        phaseNxt = PH_IDLE;
        cntNxt   = CNT_ZERO;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase     <= PH_IDLE;
      cnt       <= CNT_ZERO;
      isWr      <= 1'b0;
      doneValid <= 1'b0;
    end else begin
      phase     <= phaseNxt;
      cnt       <= cntNxt;
      isWr      <= isWrNxt;
      doneValid <= doneNxt;
    end
  end

  always_comb begin
    strb.phase   = phase;
    strb.isWrite = isWr;
    strb.load    = loadNow;
    strb.capture = captureNow;
  end

  // R2: completion lasts a single cycle
  assert_done_single_R2: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R10: a waiting write never leaves float early
  assert_float_holds_write_R10: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_FLOAT && cnt != CNT_ZERO && reqValid && reqWrite)
      |=> (phase == PH_FLOAT || phase == PH_IDLE));
endmodule

// File: rtl/xbusSeqData.sv
`timescale 1ns/1ps
module xbusSeqData
  import xbusPkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] busDataIn,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic [DATA_W-1:0] rdData
);
  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdQ;
  logic              inAccess, inPulse;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrQ  <= '0;
      wdataQ <= '0;
    end else if (strb.load) begin
      addrQ  <= reqAddr;
      wdataQ <= reqWdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)             rdQ <= '0;
    else if (strb.capture) rdQ <= busDataIn;
  end

  assign inPulse  = (strb.phase == PH_PULSE);
  assign inAccess = (strb.phase == PH_SETUP) || inPulse || (strb.phase == PH_HOLD);

  assign busAddr    = addrQ;
  assign busDataOut = wdataQ;
  assign busDataOe  = inAccess && strb.isWrite;
  assign rdStrobeN  = !(inPulse && !strb.isWrite);
  assign wrStrobeN  = !(inPulse && strb.isWrite);
  assign rdData     = rdQ;

  // R4: read data only moves on a capture
  assert_rdata_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.capture |=> $stable(rdData));

  // R3: address held through the access
  assert_addr_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    inAccess |=> $stable(busAddr));
endmodule

// File: rtl/xbusSeq.sv
`timescale 1ns/1ps
module xbusSeq
  import xbusPkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 8,
  parameter int CNT_W       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              reqReady,
  input  logic [CNT_W-1:0]  cfgRdSetup,
  input  logic [CNT_W-1:0]  cfgRdPulse,
  input  logic [CNT_W-1:0]  cfgRdHold,
  input  logic [CNT_W-1:0]  cfgWrSetup,
  input  logic [CNT_W-1:0]  cfgWrPulse,
  input  logic [CNT_W-1:0]  cfgWrHold,
  input  logic [CNT_W-1:0]  cfgFloat,
  input  logic [1:0]        cfgWaitMode,
  input  logic              waitN,
  output logic [ADDR_W-1:0] busAddr,
  output logic [DATA_W-1:0] busDataOut,
  output logic              busDataOe,
  input  logic [DATA_W-1:0] busDataIn,
  output logic              rdStrobeN,
  output logic              wrStrobeN,
  output logic              doneValid,
  output logic [DATA_W-1:0] rdData,
  output logic              cfgInvalid
);
  logic       waitAct;
  seqStrobe_t strb;

  xbusWaitSync #(.STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .waitN(waitN), .waitAct(waitAct)
  );

  xbusSeqCtrl #(.CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqReady(reqReady),
    .cfgRdSetup(cfgRdSetup), .cfgRdPulse(cfgRdPulse), .cfgRdHold(cfgRdHold),
    .cfgWrSetup(cfgWrSetup), .cfgWrPulse(cfgWrPulse), .cfgWrHold(cfgWrHold),
    .cfgFloat(cfgFloat), .cfgWaitMode(cfgWaitMode), .waitAct(waitAct),
    .doneValid(doneValid), .cfgInvalid(cfgInvalid), .strb(strb)
  );

  xbusSeqData #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .busDataIn(busDataIn),
    .busAddr(busAddr), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN), .rdData(rdData)
  );

  // R6: a frozen pulse cycle changes no bus output
  assert_freeze_stable_R6: assert property (@(posedge clk) disable iff (!rstN)
    (cfgWaitMode == WM_FROZEN && waitAct && (!rdStrobeN || !wrStrobeN))
      |=> ($stable(rdStrobeN) && $stable(wrStrobeN) && $stable(busAddr)
           && $stable(busDataOe) && $stable(busDataOut)));

  // R3: never both strobes at once
  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({~rdStrobeN, ~wrStrobeN}));

  // R3: bus never driven against a read strobe
  assert_oe_not_read_R3: assert property (@(posedge clk) disable iff (!rstN)
    busDataOe |-> rdStrobeN);
endmodule

// File: tb/tb_xbusSeq.sv
`timescale 1ns/1ps
module tb_xbusSeq;
  localparam int AW = 8;
  localparam int DW = 8;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          reqValid = 1'b0, reqWrite = 1'b0;
  logic [AW-1:0] reqAddr = '0;
  logic [DW-1:0] reqWdata = '0;
  logic          reqReady;
  logic [CW-1:0] cfgRdSetup = '0, cfgRdPulse = 4'd1, cfgRdHold = '0;
  logic [CW-1:0] cfgWrSetup = '0, cfgWrPulse = 4'd1, cfgWrHold = '0;
  logic [CW-1:0] cfgFloat = '0;
  logic [1:0]    cfgWaitMode = 2'd0;
  logic          waitN = 1'b1;
  logic [AW-1:0] busAddr;
  logic [DW-1:0] busDataOut, busDataIn, rdData;
  logic          busDataOe, rdStrobeN, wrStrobeN, doneValid, cfgInvalid;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  assign busDataIn = 8'(cyc);

  xbusSeq #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqWdata(reqWdata), .reqReady(reqReady),
    .cfgRdSetup(cfgRdSetup), .cfgRdPulse(cfgRdPulse), .cfgRdHold(cfgRdHold),
    .cfgWrSetup(cfgWrSetup), .cfgWrPulse(cfgWrPulse), .cfgWrHold(cfgWrHold),
    .cfgFloat(cfgFloat), .cfgWaitMode(cfgWaitMode), .waitN(waitN),
    .busAddr(busAddr), .busDataOut(busDataOut), .busDataOe(busDataOe),
    .busDataIn(busDataIn), .rdStrobeN(rdStrobeN), .wrStrobeN(wrStrobeN),
    .doneValid(doneValid), .rdData(rdData), .cfgInvalid(cfgInvalid)
  );

  // results of the last access
  int resDone, resPw, resStart, resOe, resStalls, resBusyRdy, resAddr, resData, resRd, resDoneCyc;

  task automatic chk(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  task automatic runAccess(input bit wr, input bit skipSync, input int addr, input int wd,
                           input int lowAt, input int highAt);
    int idx;
    if (!skipSync) @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = 8'(addr); reqWdata = 8'(wd);
    #1;
    resStalls = 0;
    while (!reqReady && resStalls < 100) begin
      @(negedge clk); #1; resStalls++;
    end
    idx = 0; resPw = 0; resStart = 0; resOe = 0; resBusyRdy = 0; resDone = -1;
    while (resDone < 0 && idx < 300) begin
      @(negedge clk);
      idx++;
      reqValid = 1'b0;
      if (!rdStrobeN || !wrStrobeN) begin
        resPw++;
        if (resStart == 0) begin
          resStart = idx; resAddr = busAddr; resData = busDataOut;
        end
      end
      if (busDataOe) resOe++;
      if (doneValid) begin
        resDone = idx; resRd = rdData; resDoneCyc = cyc;
      end else if (reqReady) begin
        resBusyRdy++;
      end
      if (idx == lowAt)  waitN = 1'b0;
      if (idx == highAt) waitN = 1'b1;
    end
  endtask

  function automatic int pEff(input int p);
    return (p == 0) ? 1 : p;
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    summary();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk("R1 rdStrobeN in reset", int'(rdStrobeN), 1);
    chk("R1 wrStrobeN in reset", int'(wrStrobeN), 1);
    chk("R1 oe in reset", int'(busDataOe), 0);
    chk("R1 done in reset", int'(doneValid), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 ready after reset", int'(reqReady), 1);
    chk("R1 oe after reset", int'(busDataOe), 0);

    // R2/R3/R4/R11 sweep, wait off, no float
    for (int wr = 0; wr < 2; wr++)
      for (int s = 0; s < 3; s++)
        for (int p = 0; p < 4; p++)
          for (int h = 0; h < 3; h++) begin
            int ad, wd, pe;
            ad = s * 16 + p * 4 + h + wr * 100;
            wd = ad ^ 8'h5A;
            pe = pEff(p);
            if (wr == 1) begin
              cfgWrSetup = 4'(s); cfgWrPulse = 4'(p); cfgWrHold = 4'(h);
              cfgRdSetup = 4'd3;  cfgRdPulse = 4'd3;  cfgRdHold = 4'd3;
            end else begin
              cfgRdSetup = 4'(s); cfgRdPulse = 4'(p); cfgRdHold = 4'(h);
              cfgWrSetup = 4'd3;  cfgWrPulse = 4'd3;  cfgWrHold = 4'd3;
            end
            runAccess(wr[0], 1'b0, ad, wd, -1, -1);
            chk("R2 done cycle", resDone, s + pe + h + 1);
            chk("R2 pulse width", resPw, pe);
            chk("R2 strobe start", resStart, s + 1);
            chk("R3 oe cycles", resOe, (wr == 1) ? s + pe + h : 0);
            chk("R3 address", resAddr, ad & 255);
            chk("R11 ready low while busy", resBusyRdy, 0);
            if (wr == 1) chk("R3 write data", resData, wd & 255);
            else         chk("R4 read data", resRd, (resDoneCyc - 1 - h) & 255);
          end

    // R10 float sweep: read then waiting write
    cfgRdSetup = 4'd1; cfgRdPulse = 4'd1;
    cfgWrSetup = 4'd1; cfgWrPulse = 4'd1; cfgWrHold = 4'd1;
    for (int h = 1; h < 3; h++)
      for (int f = 0; f < 7; f++) begin
        cfgRdHold = 4'(h); cfgFloat = 4'(f);
        runAccess(1'b0, 1'b0, 8'h11, 0, -1, -1);
        runAccess(1'b1, 1'b1, 8'h22, 8'h33, -1, -1);
        chk("R10 write stall after read", resStalls, (f > h) ? f - h - 1 : 0);
        chk("R10 write done", resDone, 4);
      end
    // R11 read accepted at once during float
    cfgRdHold = 4'd1; cfgFloat = 4'd6;
    runAccess(1'b0, 1'b0, 8'h44, 0, -1, -1);
    runAccess(1'b0, 1'b1, 8'h45, 0, -1, -1);
    chk("R11 read during float stall", resStalls, 0);
    runAccess(1'b1, 1'b1, 8'h46, 8'h47, -1, -1);
    chk("R11 write held in float", resStalls, 4);
    cfgFloat = 4'd0;
    repeat (8) @(negedge clk);

    // R6 frozen mode: read, then write
    cfgWaitMode = 2'd2;
    cfgRdSetup = 4'd1; cfgRdPulse = 4'd4; cfgRdHold = 4'd1;
    for (int w = 1; w < 5; w++) begin
      runAccess(1'b0, 1'b0, 8'h50, 0, 2, 2 + w);
      chk("R6 frozen pulse width", resPw, 4 + w);
      chk("R6 frozen done", resDone, 7 + w);
      chk("R4 read data after freeze", resRd, (resDoneCyc - 2) & 255);
      repeat (4) @(negedge clk);
    end
    cfgWrSetup = 4'd1; cfgWrPulse = 4'd4; cfgWrHold = 4'd1;
    runAccess(1'b1, 1'b0, 8'h60, 8'h61, 2, 4);
    chk("R6 frozen write width", resPw, 6);
    chk("R6 frozen write oe", resOe, 8);
    repeat (4) @(negedge clk);

    // R8 wait seen only in setup, then only in hold
    cfgRdSetup = 4'd4; cfgRdPulse = 4'd2; cfgRdHold = 4'd3;
    runAccess(1'b0, 1'b0, 8'h70, 0, 1, 2);
    chk("R8 wait in setup width", resPw, 2);
    chk("R8 wait in setup done", resDone, 10);
    repeat (4) @(negedge clk);
    runAccess(1'b0, 1'b0, 8'h71, 0, 7, 8);
    chk("R8 wait in hold width", resPw, 2);
    chk("R8 wait in hold done", resDone, 10);
    repeat (4) @(negedge clk);

    // R7 ready mode, release swept around terminal count
    cfgWaitMode = 2'd3;
    cfgRdSetup = 4'd1; cfgRdPulse = 4'd2; cfgRdHold = 4'd1;
    for (int r = 1; r < 7; r++) begin
      int last;
      waitN = 1'b0;
      repeat (3) @(negedge clk);
      runAccess(1'b0, 1'b0, 8'h80, 0, -1, r);
      last = (r + 2 > 3) ? r + 2 : 3;
      chk("R7 ready pulse width", resPw, last - 1);
      chk("R7 ready done", resDone, last + 2);
      repeat (3) @(negedge clk);
    end

    // R5 modes 0 and 1 ignore a low wait pin
    for (int m = 0; m < 2; m++) begin
      cfgWaitMode = 2'(m);
      waitN = 1'b0;
      repeat (3) @(negedge clk);
      runAccess(1'b0, 1'b0, 8'h90, 0, -1, -1);
      chk("R5 wait ignored width", resPw, 2);
      chk("R5 wait ignored done", resDone, 5);
      waitN = 1'b1;
      repeat (3) @(negedge clk);
    end

    // R9 configuration flag
    @(negedge clk);
    cfgWaitMode = 2'd2; cfgRdHold = 4'd0; cfgWrHold = 4'd1; #1;
    chk("R9 frozen zero read hold", int'(cfgInvalid), 1);
    cfgWaitMode = 2'd3; cfgRdHold = 4'd1; cfgWrHold = 4'd0; #1;
    chk("R9 ready zero write hold", int'(cfgInvalid), 1);
    cfgWaitMode = 2'd0; #1;
    chk("R9 wait off zero hold", int'(cfgInvalid), 0);
    cfgWaitMode = 2'd2; cfgWrHold = 4'd1; #1;
    chk("R9 holds nonzero", int'(cfgInvalid), 0);

    summary();
  end
endmodule